// File: doc/BRIEF.md
# UART Status Flag and Request Controller

This block keeps the event and status flags of a UART that has a one-entry transmit holding buffer and a two-byte receive queue. It sits between the serial datapath and the CPU. The shifter side tells it when a stop bit has gone out and when an overrun was seen. The shifter also moves bytes in and out over two valid/ready streams. The CPU side reaches the flags, the interrupt enables, the DMA enables and the data ports through a simple word bus. From the flags and their enables the block drives one interrupt line and one DMA request line per channel.

Each flag has its own set and clear rule. The two receive-occupancy flags follow the queue depth. The framing and parity flags can be cleared by writing 1 or by reading the byte that carried the error. The overrun and end-of-transmission flags clear only by a write of 1. The transmit-empty flag clears only when new transmit data is written. When a set event and a clear event reach a flag in the same cycle, the set wins. A synchronous software reset input empties both buffers and returns the flags to their idle values. It leaves all enables untouched.

Back-pressure rules: the receive stream accepts a byte in a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` is low while two bytes are held, and a producer that has no room must report the lost byte on `rx_ovr`. The transmit stream offers the held byte on `tx_data` while `tx_valid` is high. A cycle with `tx_valid` and `tx_ready` both high moves the byte into the shift register.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After `rst_n` is released, the flag register reads 0x01 (only the transmit-empty flag set), the enables read 0, `irq` and all `dma_req` bits are 0, `rx_ready` is 1 and `tx_valid` is 0.
- R2: Flag bit 0 (transmit empty) sets in the cycle after a `tx_valid`/`tx_ready` transfer and clears after a bus write to address 2, which loads `tx_data` and raises `tx_valid`.
- R3: Flag bit 1 (end of transmission) sets after a `tx_stop_done` strobe only if bit 0 is 1 in that cycle. Otherwise it stays 0.
- R4: A bus write to address 0 clears each of flag bits 1, 4, 5 and 6 where the written bit is 1. Written 0s have no effect, and written 1s on bits 0, 2 and 3 have no effect.
- R5: The receive queue holds up to two bytes in arrival order. `rx_ready` is 0 while it holds two. A bus read of address 2 returns the oldest byte and removes it. A read while the queue is empty returns 0 and changes nothing.
- R6: Flag bit 2 (one byte held) sets when a byte enters the empty queue and clears when a read leaves the queue empty. It is 1 exactly while the queue holds at least one byte.
- R7: Flag bit 3 (two bytes held) sets when a second byte is stored while the first is still held. Any read that removes a byte clears it.
- R8: Flag bit 6 (framing) and bit 5 (parity) set when an accepted byte carries `rx_frm_err` or `rx_par_err`. A read clears them only when the removed byte carries that same error.
- R9: Flag bit 4 (overrun) sets on an `rx_ovr` strobe. Reads of received data do not clear it.
- R10: When a set and a clear event reach one flag in the same cycle, the flag ends up 1.
- R11: `irq` is 1 exactly while some flag bit and the same bit of the interrupt enable register (address 1, bits 6..0) are both 1.
- R12: The DMA enable register at address 3 holds the per-channel receive enables in bits NCH-1..0 and the transmit enables in bits 2·NCH-1..NCH. `dma_req[c]` = (flag bit 2 AND receive enable c) OR (flag bit 0 AND transmit enable c). An interrupt enable on bit 0 or bit 2 must never be set together with any DMA enable on the same flag.
- R13: A `soft_rst` cycle returns the flags to 0x01, empties the receive queue and drops `tx_valid`, and keeps the interrupt and DMA enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset of flags and buffers |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe (reads of address 2 remove a byte) |
| bus_addr | input | 2 | Register address: 0 flags, 1 interrupt enables, 2 data, 3 DMA enables |
| bus_wdata | input | DW | Bus write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| tx_valid | output | 1 | Transmit holding buffer is full |
| tx_ready | input | 1 | Shift register takes the held byte |
| tx_data | output | DW | Held transmit byte |
| tx_stop_done | input | 1 | Strobe: stop bit has been sent |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Receive queue has room |
| rx_data | input | DW | Received byte |
| rx_frm_err | input | 1 | Offered byte has a framing error |
| rx_par_err | input | 1 | Offered byte has a parity error |
| rx_ovr | input | 1 | Strobe: a byte was lost to overrun |
| irq | output | 1 | Interrupt request |
| dma_req | output | NCH | DMA request per channel |

## Verification
The bench goes after the cases where rules collide. One case is a read that removes a clean byte while an errored byte waits behind it: a design that clears the error flag on any read would drop it early. Another is a write-1-to-clear arriving in the same cycle as a fresh framing error: with the wrong priority the error would be lost. A third is a stop bit reported while new transmit data is pending, where an unguarded design would raise end-of-transmission falsely. The bench also offers a third byte to a full queue, expecting it to be held back rather than overwrite the oldest. It reads the overrun flag after data reads, where a design that shares the error clear path would wrongly lose it.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int NF = 7;

  // flag bit positions
  localparam int F_TBE  = 0;
  localparam int F_TEND = 1;
  localparam int F_RB1  = 2;
  localparam int F_RB2  = 3;
  localparam int F_OVR  = 4;
  localparam int F_PAR  = 5;
  localparam int F_FRM  = 6;

  // bits that software may clear by writing 1
  localparam logic [NF-1:0] W1C_MASK = 7'b111_0010;
  // idle value: transmit buffer empty
  localparam logic [NF-1:0] FLAG_IDLE = 7'b000_0001;

  typedef enum logic [1:0] {
    A_FLAGS = 2'd0,
    A_IEN   = 2'd1,
    A_DATA  = 2'd2,
    A_DMAEN = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_frm,
  input  logic          in_par,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic          head_frm,
  output logic          head_par,
  output logic [1:0]    count
);
  localparam int EW = DW + 2;

  logic [EW-1:0] mem [2];
  logic          rd_ptr;
  logic          wr_ptr;
  logic          do_push;
  logic          do_pop;
  logic [EW-1:0] head;

  assign in_ready = (count != 2'd2);
  assign do_push  = in_valid && in_ready && !soft_rst;
  assign do_pop   = pop && (count != 2'd0) && !soft_rst;
  assign wr_ptr   = rd_ptr ^ count[0];
  assign head     = (count != 2'd0) ? mem[rd_ptr] : '0;

  assign head_data = head[DW-1:0];
  assign head_par  = head[DW];
  assign head_frm  = head[DW+1];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= {in_frm, in_par, in_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= 2'd0;
      rd_ptr <= 1'b0;
    end else if (soft_rst) begin
      count  <= 2'd0;
      rd_ptr <= 1'b0;
    end else begin
      if (do_pop) rd_ptr <= ~rd_ptr;
      case ({do_push, do_pop})
        2'b10:   count <= count + 2'd1;
        2'b01:   count <= count - 2'd1;
        default: count <= count;
      endcase
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= 2'd2);

  // R5
  pop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push) |=> (count == $past(count) - 2'd1));
endmodule

// File: rtl/uart_flag_bank.sv
module uart_flag_bank #(
  parameter int              NF  = 7,
  parameter logic [NF-1:0]   IDLE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [NF-1:0] set_ev,
  input  logic [NF-1:0] clr_ev,
  output logic [NF-1:0] flags
);
  for (genvar i = 0; i < NF; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags[i] <= IDLE[i];
      else if (soft_rst)  flags[i] <= IDLE[i];
      else if (set_ev[i]) flags[i] <= 1'b1;
      else if (clr_ev[i]) flags[i] <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_ev[i] && !soft_rst) |=> flags[i]);
  end
endmodule

// File: rtl/uart_req_gen.sv
module uart_req_gen #(
  parameter int NF     = 7,
  parameter int NCH    = 2,
  parameter int RX_BIT = 2,
  parameter int TX_BIT = 0
) (
  input  logic [NF-1:0]  flags,
  input  logic [NF-1:0]  ien,
  input  logic [NCH-1:0] rx_den,
  input  logic [NCH-1:0] tx_den,
  output logic           irq,
  output logic [NCH-1:0] dma_req
);
  assign irq = |(flags & ien);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign dma_req[c] = (flags[RX_BIT] && rx_den[c]) ||
                        (flags[TX_BIT] && tx_den[c]);
  end
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
#(
  parameter int DW  = 8,
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [1:0]     bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [DW-1:0]  tx_data,
  input  logic           tx_stop_done,
  input  logic           rx_valid,
  output logic           rx_ready,
  input  logic [DW-1:0]  rx_data,
  input  logic           rx_frm_err,
  input  logic           rx_par_err,
  input  logic           rx_ovr,
  output logic           irq,
  output logic [NCH-1:0] dma_req
);
  // DW must cover NF flag bits and 2*NCH DMA enable bits
  localparam int DEN_W = 2 * NCH;

  reg_addr_e       addr;
  logic            wr_flags, wr_ien, wr_data, wr_den, rd_data;
  logic [NF-1:0]   flags, ien, set_ev, clr_ev, w1c;
  logic [NCH-1:0]  rx_den, tx_den;
  logic            tx_hs, rx_push, pop_ok;
  logic [DW-1:0]   head_data;
  logic            head_frm, head_par;
  logic [1:0]      rx_cnt;

  assign addr     = reg_addr_e'(bus_addr);
  assign wr_flags = bus_wr && (addr == A_FLAGS);
  assign wr_ien   = bus_wr && (addr == A_IEN);
  assign wr_data  = bus_wr && (addr == A_DATA);
  assign wr_den   = bus_wr && (addr == A_DMAEN);
  assign rd_data  = bus_rd && (addr == A_DATA);

  assign tx_hs    = tx_valid && tx_ready;
  assign rx_push  = rx_valid && rx_ready;
  assign pop_ok   = rd_data && (rx_cnt != 2'd0);
  assign w1c      = wr_flags ? (bus_wdata[NF-1:0] & W1C_MASK) : '0;

  // ---------------- enables ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien    <= '0;
      rx_den <= '0;
      tx_den <= '0;
    end else begin
      if (wr_ien) ien <= bus_wdata[NF-1:0];
      if (wr_den) begin
        rx_den <= bus_wdata[NCH-1:0];
        tx_den <= bus_wdata[DEN_W-1:NCH];
      end
    end
  end

  // ---------------- transmit holding buffer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (soft_rst) begin
      tx_valid <= 1'b0;
    end else if (wr_data) begin
      tx_valid <= 1'b1;
      tx_data  <= bus_wdata;
    end else if (tx_hs) begin
      tx_valid <= 1'b0;
    end
  end

  // ---------------- receive queue ----------------
  uart_rx_fifo #(.DW(DW)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .in_valid  (rx_valid),
    .in_ready  (rx_ready),
    .in_data   (rx_data),
    .in_frm    (rx_frm_err),
    .in_par    (rx_par_err),
    .pop       (rd_data),
    .head_data (head_data),
    .head_frm  (head_frm),
    .head_par  (head_par),
    .count     (rx_cnt)
  );

  // ---------------- flag events ----------------
  always_comb begin
    set_ev = '0;
    clr_ev = w1c;
    set_ev[F_TBE]  = tx_hs;
    clr_ev[F_TBE]  = wr_data;
    set_ev[F_TEND] = tx_stop_done && flags[F_TBE];
    set_ev[F_RB1]  = rx_push && (rx_cnt == 2'd0);
    clr_ev[F_RB1]  = pop_ok && (rx_cnt == 2'd1) && !rx_push;
    set_ev[F_RB2]  = rx_push && (rx_cnt == 2'd1) && !pop_ok;
    clr_ev[F_RB2]  = pop_ok;
    set_ev[F_OVR]  = rx_ovr;
    set_ev[F_PAR]  = rx_push && rx_par_err;
    clr_ev[F_PAR]  = w1c[F_PAR] || (pop_ok && head_par);
    set_ev[F_FRM]  = rx_push && rx_frm_err;
    clr_ev[F_FRM]  = w1c[F_FRM] || (pop_ok && head_frm);
  end

  uart_flag_bank #(.NF(NF), .IDLE(FLAG_IDLE)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .set_ev   (set_ev),
    .clr_ev   (clr_ev),
    .flags    (flags)
  );

  uart_req_gen #(.NF(NF), .NCH(NCH), .RX_BIT(F_RB1), .TX_BIT(F_TBE)) u_req (
    .flags   (flags),
    .ien     (ien),
    .rx_den  (rx_den),
    .tx_den  (tx_den),
    .irq     (irq),
    .dma_req (dma_req)
  );

  // ---------------- read mux ----------------
  always_comb begin
    bus_rdata = '0;
    case (addr)
      A_FLAGS: bus_rdata[NF-1:0]    = flags;
      A_IEN:   bus_rdata[NF-1:0]    = ien;
      A_DATA:  bus_rdata            = head_data;
      A_DMAEN: bus_rdata[DEN_W-1:0] = {tx_den, rx_den};
      default: bus_rdata            = '0;
    endcase
  end

  // ---------------- assertions ----------------
  // R2
  tbe_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !tx_hs && !soft_rst) |=> !flags[F_TBE]);

  // R3
  tend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_TEND]) |-> ($past(tx_stop_done) && $past(flags[F_TBE])));

  // R6
  rb1_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[F_RB1] == (rx_cnt != 2'd0));

  // R7
  rb2_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags[F_RB2] |-> (rx_cnt == 2'd2));

  // R9
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[F_OVR] && !soft_rst && !w1c[F_OVR]) |=> flags[F_OVR]);

  // R12
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((ien[F_RB1] && (|rx_den)) || (ien[F_TBE] && (|tx_den))));
endmodule

// File: tb/tb_uart_flag_ctrl.sv
module tb_uart_flag_ctrl;
  localparam int DW  = 8;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n, soft_rst, bus_wr, bus_rd;
  logic [1:0]     bus_addr;
  logic [DW-1:0]  bus_wdata, bus_rdata, tx_data, rx_data;
  logic           tx_valid, tx_ready, tx_stop_done;
  logic           rx_valid, rx_ready, rx_frm_err, rx_par_err, rx_ovr, irq;
  logic [NCH-1:0] dma_req;

  always #5 clk = ~clk;

  uart_flag_ctrl #(.DW(DW), .NCH(NCH)) dut (.*);

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  // reference model state
  logic [6:0]     m_flags, m_ien;
  logic [NCH-1:0] m_rxen, m_txen;
  logic           m_txfull;
  logic [DW-1:0]  m_txbuf;
  logic [DW+1:0]  m_q[$];   // {frm, par, data}

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_rdata();
    case (bus_addr)
      2'd0: return DW'(m_flags);
      2'd1: return DW'(m_ien);
      2'd2: return (m_q.size() > 0) ? m_q[0][DW-1:0] : '0;
      default: return DW'({m_txen, m_rxen});
    endcase
  endfunction

  task automatic idle_inputs();
    soft_rst = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    tx_ready = 0; tx_stop_done = 0; rx_valid = 0; rx_data = 0;
    rx_frm_err = 0; rx_par_err = 0; rx_ovr = 0;
  endtask

  task automatic model_reset();
    m_flags = 7'h01; m_ien = 0; m_rxen = 0; m_txen = 0;
    m_txfull = 0; m_txbuf = 0; m_q.delete();
  endtask

  task automatic model_step();
    int n;
    logic push, pop, hs, wrtx;
    logic [6:0] set_m, clr_m;
    logic [DW+1:0] head;
    n    = m_q.size();
    push = rx_valid && (n < 2);
    pop  = bus_rd && (bus_addr == 2'd2) && (n > 0);
    hs   = tx_ready && m_txfull;
    wrtx = bus_wr && (bus_addr == 2'd2);
    head = (n > 0) ? m_q[0] : '0;
    if (bus_wr && bus_addr == 2'd1) m_ien = bus_wdata[6:0];
    if (bus_wr && bus_addr == 2'd3) begin
      m_rxen = bus_wdata[NCH-1:0];
      m_txen = bus_wdata[2*NCH-1:NCH];
    end
    if (soft_rst) begin
      m_flags = 7'h01; m_q.delete(); m_txfull = 0;
    end else begin
      set_m = 0; clr_m = 0;
      if (bus_wr && bus_addr == 2'd0) clr_m = bus_wdata[6:0] & 7'h72;
      if (hs) set_m[0] = 1;
      if (wrtx) clr_m[0] = 1;
      if (tx_stop_done && m_flags[0]) set_m[1] = 1;
      if (push && n == 0) set_m[2] = 1;
      if (pop && n == 1 && !push) clr_m[2] = 1;
      if (push && n == 1 && !pop) set_m[3] = 1;
      if (pop) clr_m[3] = 1;
      if (rx_ovr) set_m[4] = 1;
      if (push && rx_par_err) set_m[5] = 1;
      if (pop && head[DW]) clr_m[5] = 1;
      if (push && rx_frm_err) set_m[6] = 1;
      if (pop && head[DW+1]) clr_m[6] = 1;
      m_flags = (m_flags & ~clr_m) | set_m;
      if (pop) void'(m_q.pop_front());
      if (push) m_q.push_back({rx_frm_err, rx_par_err, rx_data});
      if (wrtx) begin m_txfull = 1; m_txbuf = bus_wdata; end
      else if (hs) m_txfull = 0;
    end
  endtask

  // compare outputs, advance one clock, update the model, return inputs to idle
  task automatic tick();
    logic [NCH-1:0] ed;
    #1;
    for (int c = 0; c < NCH; c++)
      ed[c] = (m_flags[2] && m_rxen[c]) || (m_flags[0] && m_txen[c]);
    chk("irq (R11)", irq, |(m_flags & m_ien));
    chk("dma_req (R12)", dma_req, ed);
    chk("rx_ready (R5)", rx_ready, m_q.size() < 2);
    chk("tx_valid (R2)", tx_valid, m_txfull);
    if (m_txfull) chk("tx_data (R2)", tx_data, m_txbuf);
    chk("bus_rdata", bus_rdata, exp_rdata());
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; tick();
  endtask

  task automatic rd(logic [1:0] a);
    bus_rd = 1; bus_addr = a; tick();
  endtask

  task automatic push(logic [DW-1:0] d, logic fe, logic pe);
    rx_valid = 1; rx_data = d; rx_frm_err = fe; rx_par_err = pe; tick();
  endtask

  // check the flag register by a hand-worked value
  task automatic flags_are(logic [6:0] e);
    bus_addr = 2'd0; #1;
    chk("flags", bus_rdata, DW'(e));
    tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    tag = "R1";
    flags_are(7'h01);
    tick();

    tag = "R2";
    wr(2'd2, 8'hA5);            // load, TBE clears
    flags_are(7'h00);
    tx_ready = 1; tick();       // transfer, TBE sets
    flags_are(7'h01);

    tag = "R3";
    tx_stop_done = 1; tick();   // TBE=1 -> TEND sets
    flags_are(7'h03);
    wr(2'd0, 8'h02);            // clear TEND
    wr(2'd2, 8'h3C);            // TBE clears
    tx_stop_done = 1; tick();   // TEND must stay 0
    flags_are(7'h00);
    tx_ready = 1; tick();

    tag = "R4";
    tx_stop_done = 1; tick();
    rx_ovr = 1; tick();
    push(8'h11, 1, 1);          // flags 0x77
    flags_are(7'h77);
    wr(2'd0, 8'h00);            // zeros do nothing
    flags_are(7'h77);
    wr(2'd0, 8'hFF);            // only bits 1,4,5,6 clear
    flags_are(7'h05);
    rd(2'd2);

    tag = "R5";
    push(8'h21, 0, 0);
    push(8'h22, 0, 0);
    flags_are(7'h0D);           // R6 R7 both set
    rx_valid = 1; rx_data = 8'h23; tick();   // full: held back
    rd(2'd2);
    rd(2'd2);
    tag = "R6";
    flags_are(7'h01);
    tag = "R5";
    rd(2'd2);                   // empty read
    push(8'h31, 0, 0);
    rx_valid = 1; rx_data = 8'h32; bus_rd = 1; bus_addr = 2'd2; tick(); // push+pop
    tag = "R7";
    flags_are(7'h05);
    push(8'h33, 0, 0);
    rd(2'd2);
    flags_are(7'h05);
    rd(2'd2);

    tag = "R8";
    push(8'h41, 0, 0);
    push(8'h42, 1, 0);
    rd(2'd2);                   // clean byte: FE stays
    flags_are(7'h45);
    rd(2'd2);                   // errored byte: FE clears
    flags_are(7'h01);
    push(8'h43, 0, 1);
    push(8'h44, 0, 0);
    rd(2'd2);                   // PE byte removed
    flags_are(7'h0D & 7'h05 | 7'h05);
    rd(2'd2);

    tag = "R9";
    rx_ovr = 1; tick();
    push(8'h51, 0, 0);
    rd(2'd2);
    flags_are(7'h11);
    wr(2'd0, 8'h10);
    flags_are(7'h01);

    tag = "R10";
    push(8'h61, 1, 0);
    rx_valid = 1; rx_data = 8'h62; rx_frm_err = 1;
    bus_wr = 1; bus_addr = 2'd0; bus_wdata = 8'h40; tick();
    flags_are(7'h4D);
    rd(2'd2); rd(2'd2);
    wr(2'd0, 8'h40);

    tag = "R11";
    wr(2'd1, 8'h02);            // enable TEND only
    tick();
    tx_stop_done = 1; tick();
    tick();
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h7F);
    push(8'h71, 0, 0);
    rd(2'd2);
    wr(2'd1, 8'h00);

    tag = "R12";
    wr(2'd3, 8'h09);            // rx ch0, tx ch1
    tick();
    push(8'h81, 0, 0);
    wr(2'd2, 8'h99);            // TBE clears -> ch1 drops
    tick();
    tx_ready = 1; tick();
    rd(2'd2);

    tag = "R13";
    wr(2'd2, 8'h5A);
    push(8'h91, 1, 1);
    rx_ovr = 1; tick();
    soft_rst = 1; tick();
    flags_are(7'h01);
    bus_addr = 2'd3; tick();    // enables kept
    wr(2'd3, 8'h00);
    tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule